// File: doc/BRIEF.md
# Escaped Message Stream Encoder

This block turns an outbound message, held in a byte-addressed buffer in the usual block-transfer layout (byte 0 is a length, byte 1 the function code, byte 2 the sequence number, then the body), into a framed serial byte stream. A start strobe makes the encoder walk the buffer through a combinational read port and produce bytes on a valid/ready output. The buffer's length byte is dropped and the two header bytes swap places. Any byte that collides with one of the three framing codes is escaped. A checksum byte follows the body, and a terminator closes the frame.

A connect strobe makes the encoder emit a short version handshake command instead of a message. A single cycle pulse marks the acceptance of each message terminator, so the producer knows when it may refill the buffer.

Top module: `esc_stream_enc`

## Requirements
- R1: After synchronous reset `out_valid_o` and `done_o` are low and stay low until a start or connect strobe is accepted.
- R2: For a buffer of `msg_len_i` bytes (3 or more), buffer byte 0 is never sent. The body goes out as byte 2, then byte 1, then bytes 3 up to `msg_len_i`-1 in ascending order.
- R3: A body byte equal to 0xA0, 0xA1 or 0xAA goes out as two beats: 0xAA, then the byte with bit 4 set (0xB0, 0xB1, 0xBA). All other bytes go out unchanged in one beat.
- R4: After the body comes the 8-bit two's complement of the modulo-256 sum of the body bytes before escaping. This checksum byte is escaped under the rule of R3.
- R5: Every message frame ends with a single unescaped 0xA0 beat.
- R6: An accepted connect strobe produces the three beats 0xFF, 0x01, 0xA1, and the final 0xA1 is not escaped.
- R7: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` and `out_data_o` hold their values on the next cycle. A beat is transferred only on a clock edge where both are high.
- R8: `done_o` is high for exactly the one cycle after the message terminator is accepted. It does not pulse after a handshake.
- R9: Start and connect strobes that arrive while a message or handshake is in progress are ignored. When both arrive together at idle, the handshake is sent and the start is dropped.
- R10: A buffer that fills the whole address range (2^`ADDR_W` bytes) is encoded completely under R2 to R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to encode the buffered message |
| connect_i | input | 1 | Request to send the version handshake |
| msg_len_i | input | ADDR_W+1 | Number of buffer bytes including the length byte; sampled with start |
| rd_addr_o | output | ADDR_W | Buffer read address |
| rd_data_i | input | 8 | Buffer byte at `rd_addr_o`, same cycle |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_ready_i | input | 1 | Downstream accepts the byte |
| done_o | output | 1 | One-cycle pulse after the message terminator is accepted |

## Verification
The bench builds the encoder with `ADDR_W` = 4, which gives a 16-byte buffer. With that size a message that fills the whole address space (R10) is a short run, and the index comparison is exercised at its top value. Buffers are chosen so that reserved codes land on both swapped header positions and in the body. One buffer's checksum works out to exactly 0xA0, so it has to be escaped. Ready is driven either always high or in an irregular stall pattern, so escape pairs and stalls overlap.

// File: rtl/enc_pkg.sv
// Package: shared codes and helpers for the escaped stream encoder.
// Assumes 8-bit stream symbols.
package enc_pkg;
    localparam logic [7:0] CODE_MSG_END = 8'hA0;
    localparam logic [7:0] CODE_CMD_END = 8'hA1;
    localparam logic [7:0] CODE_ESCAPE  = 8'hAA;
    localparam logic [7:0] CODE_VERSION = 8'hFF;
    localparam logic [7:0] PROTO_LEVEL  = 8'h01;
    localparam logic [7:0] ESC_FLIP     = 8'h10;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_HAND, SQ_BODY, SQ_SUM, SQ_TERM
    } seq_state_t;

    // True when a byte collides with a framing code.
    function automatic logic is_reserved(input logic [7:0] b);
        return (b == CODE_MSG_END) || (b == CODE_CMD_END) || (b == CODE_ESCAPE);
    endfunction
endpackage

// File: rtl/enc_sequencer.sv
// Module: enc_sequencer
// Walks the message buffer or the handshake script and presents one logical
// symbol at a time (byte plus a "send raw" flag) to the escaper. Keeps the
// running body sum for the checksum. Assumes the buffer read is combinational
// and msg_len_i >= 3 when a start is taken.
module enc_sequencer
    import enc_pkg::*;
#(
    parameter int ADDR_W = 6,
    localparam int LEN_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              connect_i,
    input  logic [LEN_W-1:0]  msg_len_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i,
    output logic              sym_valid_o,
    output logic [7:0]        sym_data_o,
    output logic              sym_raw_o,
    input  logic              sym_ready_i,
    output logic              term_fire_o
);
    seq_state_t       state;
    logic [LEN_W-1:0] pos;
    logic [LEN_W-1:0] len_q;
    logic [7:0]       sum_q;
    logic [LEN_W-1:0] addr_full;

    // Body position to buffer address: header pair swapped, rest in order.
    always_comb begin
        if (pos == '0)      addr_full = LEN_W'(2);
        else if (pos == 1)  addr_full = LEN_W'(1);
        else                addr_full = pos + LEN_W'(1);
    end
    assign rd_addr_o = addr_full[ADDR_W-1:0];

    // State, position and checksum accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            pos   <= '0;
            len_q <= '0;
            sum_q <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    pos <= '0;
                    if (connect_i) begin
                        state <= SQ_HAND;
                    end else if (start_i) begin
                        state <= SQ_BODY;
                        len_q <= msg_len_i;
                        sum_q <= '0;
                    end
                end
                SQ_HAND: if (sym_ready_i) begin
                    if (pos == LEN_W'(2)) state <= SQ_IDLE;
                    else                  pos   <= pos + 1'b1;
                end
                SQ_BODY: if (sym_ready_i) begin
                    sum_q <= sum_q + rd_data_i;
                    if (pos == len_q - LEN_W'(2)) state <= SQ_SUM;
                    else                          pos   <= pos + 1'b1;
                end
                SQ_SUM:  if (sym_ready_i) state <= SQ_TERM;
                SQ_TERM: if (sym_ready_i) state <= SQ_IDLE;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Symbol presented to the escaper in each state.
    always_comb begin
        sym_valid_o = 1'b1;
        sym_raw_o   = 1'b0;
        sym_data_o  = rd_data_i;
        case (state)
            SQ_IDLE: sym_valid_o = 1'b0;
            SQ_HAND: begin
                sym_raw_o = (pos == LEN_W'(2));
                if (pos == '0)     sym_data_o = CODE_VERSION;
                else if (pos == 1) sym_data_o = PROTO_LEVEL;
                else               sym_data_o = CODE_CMD_END;
            end
            SQ_BODY: sym_data_o = rd_data_i;
            SQ_SUM:  sym_data_o = (~sum_q) + 8'd1;
            SQ_TERM: begin
                sym_data_o = CODE_MSG_END;
                sym_raw_o  = 1'b1;
            end
            default: sym_valid_o = 1'b0;
        endcase
    end

    assign term_fire_o = (state == SQ_TERM) && sym_ready_i;

    // A start taken from idle must describe a buffer with a full header (R2).
    assert_len_header_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_IDLE && start_i && !connect_i) |-> (msg_len_i >= LEN_W'(3)));

    // Strobes while busy leave the walk in a non-idle state (R9).
    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_BODY && !sym_ready_i) |=> (state == SQ_BODY));
endmodule

// File: rtl/enc_escaper.sv
// Module: enc_escaper
// Turns each logical symbol into one or two output beats: reserved codes
// become an escape beat plus the byte with bit 4 set, unless the symbol is
// flagged raw. Assumes the symbol stays stable until it is consumed.
module enc_escaper
    import enc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sym_valid_i,
    input  logic [7:0] sym_data_i,
    input  logic       sym_raw_i,
    output logic       sym_ready_o,
    output logic       out_valid_o,
    output logic [7:0] out_data_o,
    input  logic       out_ready_i
);
    logic second_q;
    logic need_esc;
    logic beat_fire;

    assign need_esc  = !sym_raw_i && is_reserved(sym_data_i);
    assign beat_fire = sym_valid_i && out_ready_i;

    // Output beat selection: escape code, flipped byte or plain byte.
    always_comb begin
        out_valid_o = sym_valid_i;
        if (second_q)      out_data_o = sym_data_i | ESC_FLIP;
        else if (need_esc) out_data_o = CODE_ESCAPE;
        else               out_data_o = sym_data_i;
    end

    assign sym_ready_o = beat_fire && (!need_esc || second_q);

    // Track which half of an escape pair is on the output.
    always_ff @(posedge clk) begin
        if (!rst_n)                    second_q <= 1'b0;
        else if (beat_fire && need_esc) second_q <= !second_q;
    end

    // A stalled beat keeps its value (R7).
    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

    // An accepted escape beat is followed by a flipped reserved code (R3).
    assert_escape_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_ready_i && out_data_o == CODE_ESCAPE) |=>
        (out_valid_o && (out_data_o == 8'hB0 || out_data_o == 8'hB1 || out_data_o == 8'hBA)));
endmodule

// File: rtl/esc_stream_enc.sv
// Module: esc_stream_enc (top)
// Frames a buffered message or a version handshake as an escaped byte stream
// on a valid/ready output and pulses done after each message terminator.
// Assumes the buffer is not changed while a message is being sent.
module esc_stream_enc
    import enc_pkg::*;
#(
    parameter int ADDR_W = 6,
    localparam int LEN_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              connect_i,
    input  logic [LEN_W-1:0]  msg_len_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i,
    output logic              out_valid_o,
    output logic [7:0]        out_data_o,
    input  logic              out_ready_i,
    output logic              done_o
);
    logic       sym_valid;
    logic [7:0] sym_data;
    logic       sym_raw;
    logic       sym_ready;
    logic       term_fire;

    enc_sequencer #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .connect_i(connect_i),
        .msg_len_i(msg_len_i), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
        .sym_valid_o(sym_valid), .sym_data_o(sym_data), .sym_raw_o(sym_raw),
        .sym_ready_i(sym_ready), .term_fire_o(term_fire)
    );

    enc_escaper u_esc (
        .clk(clk), .rst_n(rst_n), .sym_valid_i(sym_valid), .sym_data_i(sym_data),
        .sym_raw_i(sym_raw), .sym_ready_o(sym_ready), .out_valid_o(out_valid_o),
        .out_data_o(out_data_o), .out_ready_i(out_ready_i)
    );

    // Register the completion pulse one cycle after the terminator transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= term_fire;
    end

    // Done never lasts two cycles (R8).
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // Plain 0xA0 on the output only as a terminator, followed by done (R5).
    assert_term_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_ready_i && out_data_o == CODE_MSG_END) |=> done_o);
endmodule

// File: tb/tb_esc_stream_enc.sv
module tb_esc_stream_enc;
    localparam int CLK_P = 10;
    localparam int AW = 4;
    localparam int LW = AW + 1;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, conn = 1'b0, rdy = 1'b0;
    logic [LW-1:0] len = '0;
    logic [AW-1:0] addr;
    logic [7:0] rdat, od;
    logic ov, dn;
    logic [7:0] mem [16];

    assign rdat = mem[addr];
    always #(CLK_P/2) clk = ~clk;

    esc_stream_enc #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .connect_i(conn),
        .msg_len_i(len), .rd_addr_o(addr), .rd_data_i(rdat),
        .out_valid_o(ov), .out_data_o(od), .out_ready_i(rdy), .done_o(dn)
    );

    int total = 0, bad = 0, cyc = 0, mode = 0;
    logic [7:0] exq[$];
    bit lastq[$];
    bit exp_done = 0, stalled = 0, finished = 0;
    logic [7:0] stall_data;
    string tag = "R1";

    task automatic chk(input bit ok, input string t, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
        end
    endtask

    function automatic void push_esc(input logic [7:0] b);
        if (b == 8'hA0 || b == 8'hA1 || b == 8'hAA) begin
            exq.push_back(8'hAA); lastq.push_back(0);
            exq.push_back(b | 8'h10); lastq.push_back(0);
        end else begin
            exq.push_back(b); lastq.push_back(0);
        end
    endfunction

    // Reference frame built from the requirements (R2, R3, R4, R5).
    function automatic void expect_msg(input int n);
        logic [7:0] s = 0;
        logic [7:0] body[$];
        body.push_back(mem[2]);
        body.push_back(mem[1]);
        for (int i = 3; i < n; i++) body.push_back(mem[i]);
        foreach (body[k]) begin
            s = s + body[k];
            push_esc(body[k]);
        end
        push_esc(8'(-s));
        exq.push_back(8'hA0); lastq.push_back(1);
    endfunction

    // Handshake script (R6).
    function automatic void expect_hand();
        exq.push_back(8'hFF); lastq.push_back(0);
        exq.push_back(8'h01); lastq.push_back(0);
        exq.push_back(8'hA1); lastq.push_back(0);
    endfunction

    // Per-cycle monitor against the reference queue.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            cyc++;
            chk(dn == exp_done, "R8 done pulse", dn, exp_done);
            exp_done = 0;
            if (stalled) chk(ov && od == stall_data, "R7 stall hold", od, stall_data);
            rdy = (mode == 0) ? 1'b1 : ((cyc % 4) != 2 && (cyc % 5) != 0);
            #1;
            stalled = ov && !rdy;
            stall_data = od;
            if (ov && rdy) begin
                if (exq.size() == 0) chk(0, {tag, " unexpected beat"}, od, 0);
                else begin
                    logic [7:0] b;
                    bit l;
                    b = exq.pop_front();
                    l = lastq.pop_front();
                    chk(od == b, tag, od, b);
                    exp_done = l;
                end
            end
            if (cyc > 100000) begin
                chk(0, "watchdog", cyc, 0);
                finished = 1;
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    task automatic pulse(input bit s, input bit c);
        @(negedge clk); #2;
        start = s; conn = c;
        @(negedge clk); #2;
        start = 0; conn = 0;
    endtask

    task automatic drain();
        while (exq.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic send(input int n);
        len = LW'(n);
        expect_msg(n);
        pulse(1, 0);
        drain();
    endtask

    initial begin
        foreach (mem[i]) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(ov == 0, "R1 valid in reset", ov, 0);
        chk(dn == 0, "R1 done in reset", dn, 0);
        #2 rst_n = 1;
        repeat (4) @(negedge clk);
        chk(ov == 0, "R1 valid after reset", ov, 0);

        tag = "R6 handshake";
        expect_hand(); pulse(0, 1); drain();

        tag = "R2 order";
        mem[0] = 8'h05; mem[1] = 8'h11; mem[2] = 8'h22; mem[3] = 8'h33;
        mem[4] = 8'h44; mem[5] = 8'h55;
        send(6);

        tag = "R3 escape";
        mem[0] = 8'h06; mem[1] = 8'hA1; mem[2] = 8'hAA; mem[3] = 8'hA0;
        mem[4] = 8'h12; mem[5] = 8'hB0; mem[6] = 8'hAA;
        send(7);

        tag = "R4 checksum escape";
        mem[0] = 8'h03; mem[1] = 8'h20; mem[2] = 8'h30; mem[3] = 8'h10;
        send(4);

        tag = "R7 stall";
        mode = 1;
        mem[0] = 8'h06; mem[1] = 8'hA0; mem[2] = 8'h01; mem[3] = 8'hAA;
        mem[4] = 8'hA1; mem[5] = 8'h7E; mem[6] = 8'hA0;
        send(7);
        expect_hand(); pulse(0, 1); drain();

        tag = "R10 full buffer";
        for (int i = 0; i < 16; i++) mem[i] = 8'(i * 29 + 7);
        mem[0] = 8'h0F;
        send(16);
        mode = 0;

        tag = "R5 terminator";
        mem[0] = 8'h03; mem[1] = 8'h01; mem[2] = 8'h02; mem[3] = 8'h03;
        send(4);

        tag = "R9 busy ignore";
        mode = 1;
        for (int i = 0; i < 16; i++) mem[i] = 8'(i + 1);
        len = LW'(12);
        expect_msg(12);
        pulse(1, 0);
        repeat (3) @(negedge clk);
        pulse(1, 1);
        pulse(0, 1);
        drain();
        mode = 0;
        expect_hand();
        pulse(1, 1);
        drain();
        repeat (20) @(negedge clk);
        chk(exq.size() == 0, "R9 queue empty", exq.size(), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule